// File: doc/BRIEF.md
# Serial RAM Burst Read Sequencer

This block fetches data from an external serial RAM over a four-wire SPI link. A one-cycle start request opens a transaction. Chip select goes low, and the block clocks out an 8-bit read opcode followed by a 16-bit address. It then shifts in data bytes from the memory, most significant bit first. The top four address bits come from an input nibble that is captured with the start request. The lower twelve address bits are always zero.

Each byte that has been fully received appears on a parallel output, together with a strobe that lasts one cycle. A stop input is examined while that strobe is high. If it is high, the burst ends after the byte just delivered. If it is low, the block goes straight on to the next sequential byte with no gap on the serial clock. After the burst, chip select stays released for one full serial clock period before the busy flag clears. Start requests that arrive while busy is high are dropped.

Top module: `spi_rd_seq`

## Requirements
- R1: While reset is asserted, and after it is released, csN is 1, sckOut, mosiOut, busy and byteValid are 0, and byteData is 0x00.
- R2: A start pulse sampled while busy is 0 makes csN 0 and busy 1 from the next cycle. addrHi is captured at that same clock edge.
- R3: Cycle n counts from 0, the first cycle after the start edge. In that cycle mosiOut carries preamble bit 23-n/2 of {0x03, captured addrHi, 12'h000}, sent MSB first. During the whole transaction with csN low, sckOut is 0 when n is even and 1 when n is odd. mosiOut only changes in cycles where sckOut is low.
- R4: Outside cycles 0..47, mosiOut is 0.
- R5: misoIn is sampled at every clock edge where sckOut rises in data cycles (n ≥ 48), MSB first. Byte b appears on byteData with byteValid high for exactly cycle 48+16b+15. byteData keeps that value until the next byte arrives.
- R6: lastByte is examined only in a cycle where byteValid is high. A 1 there ends the burst. A 0 there continues with the next sequential byte, with no idle serial clock in between.
- R7: After the final byte, csN is 1 and sckOut is 0 for two cycles while busy stays 1. Busy then drops to 0.
- R8: A start pulse that arrives while busy is 1, including the last cycle before busy drops, has no effect.
- R9: A start pulse in the first cycle with busy 0 after a transaction begins a new transaction at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startPulse | input | 1 | One-cycle request to begin a burst |
| lastByte | input | 1 | Ends the burst when high in a byteValid cycle |
| addrHi | input | 4 | Address bits 15:12 |
| misoIn | input | 1 | Serial data from the memory |
| csN | output | 1 | Chip select, active low |
| sckOut | output | 1 | Serial clock, half the system clock rate, idles low |
| mosiOut | output | 1 | Serial data to the memory |
| busy | output | 1 | High for the whole transaction, including the release period |
| byteValid | output | 1 | One-cycle strobe for a received byte |
| byteData | output | 8 | Last received byte |

## Verification
The hardest case to reach from the ports is a start request that lands in the final release cycle, when busy is still high but chip select has already gone back up. A request there must be dropped, yet a request one cycle later must be accepted. The bench tracks its own count of cycles since the start edge and fires injected start pulses at the exact cycle it predicts for the release window and for the middle of the preamble. It then issues a new request in the very first idle cycle. The stop input is toggled in cycles without a valid strobe, so that a design which looks at it too early gives a wrong burst length.

// File: rtl/spi_rd_pkg.sv
`timescale 1ns/1ps
package spi_rd_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_PRE, ST_DATA, ST_TAIL} seqState_t;

  typedef struct packed {
    logic loadTx;
    logic shiftTx;
    logic sckHigh;
    logic sckLow;
    logic sampleRx;
    logic emitByte;
    logic csLow;
    logic csHigh;
  } seqStrobe_t;
endpackage

// File: rtl/spi_rd_ctrl.sv
`timescale 1ns/1ps
module spi_rd_ctrl
  import spi_rd_pkg::*;
#(
  parameter int CMD_W    = 8,
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int TAIL_CYC = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic       lastByte,
  output logic       busy,
  output seqStrobe_t strb
);
  localparam int PRE_BITS = CMD_W + ADDR_W;
  localparam int MAX_CNT  = (PRE_BITS > DATA_W) ?
                            ((PRE_BITS > TAIL_CYC) ? PRE_BITS : TAIL_CYC) :
                            ((DATA_W > TAIL_CYC) ? DATA_W : TAIL_CYC);
  localparam int CNT_W    = $clog2(MAX_CNT + 1);
  localparam logic [CNT_W-1:0] PRE_LAST  = CNT_W'(PRE_BITS - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] TAIL_LAST = CNT_W'(TAIL_CYC - 1);

  seqState_t        state;
  logic             phase;
  logic [CNT_W-1:0] bitCnt;

  assign busy = (state != ST_IDLE);

  always_comb begin
    strb = '0;
    case (state)
      ST_IDLE: begin
        if (startPulse) begin
          strb.loadTx = 1'b1;
          strb.csLow  = 1'b1;
        end
      end
      ST_PRE: begin
        if (!phase) begin
          strb.sckHigh = 1'b1;
        end else begin
          strb.sckLow  = 1'b1;
          strb.shiftTx = 1'b1;
        end
      end
      ST_DATA: begin
        if (!phase) begin
          strb.sckHigh  = 1'b1;
          strb.sampleRx = 1'b1;
          strb.emitByte = (bitCnt == DATA_LAST);
        end else begin
          strb.sckLow = 1'b1;
          strb.csHigh = (bitCnt == DATA_LAST) && lastByte;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      phase  <= 1'b0;
      bitCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (startPulse) begin
            state  <= ST_PRE;
            phase  <= 1'b0;
            bitCnt <= '0;
          end
        end
        ST_PRE: begin
          phase <= ~phase;
          if (phase) begin
            if (bitCnt == PRE_LAST) begin
              state  <= ST_DATA;
              bitCnt <= '0;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
        end
        ST_DATA: begin
          phase <= ~phase;
          if (phase) begin
            if (bitCnt == DATA_LAST) begin
              bitCnt <= '0;
              if (lastByte) state <= ST_TAIL;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
        end
        default: begin
          phase <= 1'b0;
          if (bitCnt == TAIL_LAST) begin
            state  <= ST_IDLE;
            bitCnt <= '0;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
      endcase
    end
  end

  // R2
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(startPulse));

  // R7
  busy_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(state == ST_TAIL));
endmodule

// File: rtl/spi_rd_dp.sv
`timescale 1ns/1ps
module spi_rd_dp
  import spi_rd_pkg::*;
#(
  parameter int              CMD_W    = 8,
  parameter int              ADDR_W   = 16,
  parameter int              HI_W     = 4,
  parameter int              DATA_W   = 8,
  parameter logic [CMD_W-1:0] READ_CMD = 8'h03
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic [HI_W-1:0]   addrHi,
  input  logic              misoIn,
  output logic              csN,
  output logic              sckOut,
  output logic              mosiOut,
  output logic              byteValid,
  output logic [DATA_W-1:0] byteData
);
  localparam int TX_W = CMD_W + ADDR_W;
  localparam int LO_W = ADDR_W - HI_W;

  logic [TX_W-1:0]   txShift;
  logic [DATA_W-2:0] rxShift;

  assign mosiOut = txShift[TX_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift   <= '0;
      rxShift   <= '0;
      byteData  <= '0;
      byteValid <= 1'b0;
      sckOut    <= 1'b0;
      csN       <= 1'b1;
    end else begin
      byteValid <= strb.emitByte;
      if (strb.loadTx)       txShift <= {READ_CMD, addrHi, {LO_W{1'b0}}};
      else if (strb.shiftTx) txShift <= {txShift[TX_W-2:0], 1'b0};
      if (strb.sampleRx) rxShift  <= {rxShift[DATA_W-3:0], misoIn};
      if (strb.emitByte) byteData <= {rxShift, misoIn};
      if (strb.sckHigh)     sckOut <= 1'b1;
      else if (strb.sckLow) sckOut <= 1'b0;
      if (strb.csLow)       csN <= 1'b0;
      else if (strb.csHigh) csN <= 1'b1;
    end
  end

  // R5
  valid_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |=> !byteValid);

  // R3
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    sckOut |-> $stable(mosiOut));
endmodule

// File: rtl/spi_rd_seq.sv
`timescale 1ns/1ps
module spi_rd_seq
  import spi_rd_pkg::*;
#(
  parameter int CMD_W    = 8,
  parameter int ADDR_W   = 16,
  parameter int HI_W     = 4,
  parameter int DATA_W   = 8,
  parameter int TAIL_CYC = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic              lastByte,
  input  logic [HI_W-1:0]   addrHi,
  input  logic              misoIn,
  output logic              csN,
  output logic              sckOut,
  output logic              mosiOut,
  output logic              busy,
  output logic              byteValid,
  output logic [DATA_W-1:0] byteData
);
  seqStrobe_t strb;

  spi_rd_ctrl #(
    .CMD_W(CMD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAIL_CYC(TAIL_CYC)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .lastByte(lastByte),
    .busy(busy), .strb(strb)
  );

  spi_rd_dp #(
    .CMD_W(CMD_W), .ADDR_W(ADDR_W), .HI_W(HI_W), .DATA_W(DATA_W),
    .READ_CMD(CMD_W'(8'h03))
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .addrHi(addrHi), .misoIn(misoIn),
    .csN(csN), .sckOut(sckOut), .mosiOut(mosiOut),
    .byteValid(byteValid), .byteData(byteData)
  );

  // R2
  cs_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    !csN |-> busy);

  // R7
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sckOut);

  // R7
  tail_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |-> busy);

  // R5
  valid_cs_chk: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |-> !csN);
endmodule

// File: tb/spi_rd_seq_tb_top.sv
`timescale 1ns/1ps
module spi_rd_seq_tb_top;
  logic       clk = 1'b0;
  logic       rstN;
  logic       startPulse = 1'b0;
  logic       lastByte = 1'b0;
  logic [3:0] addrHi = 4'h0;
  logic       misoIn = 1'b0;
  logic       csN, sckOut, mosiOut, busy, byteValid;
  logic [7:0] byteData;

  always #2.5 clk = ~clk;

  spi_rd_seq dut_i (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .lastByte(lastByte),
    .addrHi(addrHi), .misoIn(misoIn), .csN(csN), .sckOut(sckOut),
    .mosiOut(mosiOut), .busy(busy), .byteValid(byteValid), .byteData(byteData)
  );

  int   vecs = 0;
  int   errs = 0;
  bit   done = 1'b0;
  int   mBusy = 0;
  int   n = 0;
  int   endAt = -1;
  int   base = 0;
  logic [7:0] expData = 8'h00;

  function automatic logic [7:0] memByte(int a);
    logic [15:0] x;
    logic [7:0]  m;
    x = a[15:0];
    m = x[7:0] * 8'd37;
    return m ^ x[15:8] ^ 8'h5A;
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h (n=%0d)", tag, act, exp, n);
    end
  endtask

  task automatic step(input logic st, input logic ls, input logic [3:0] hi);
    logic        eCs, eSck, eMosi, eValid;
    logic [23:0] pre;
    logic [7:0]  cur;
    @(negedge clk);
    eCs = 1'b1; eSck = 1'b0; eMosi = 1'b0; eValid = 1'b0;
    if (mBusy != 0) begin
      eCs  = (endAt >= 0 && n >= endAt - 2);
      eSck = eCs ? 1'b0 : ((n % 2) == 1);
      pre  = {8'h03, base[15:12], 12'h000};
      eMosi = (n < 48) ? pre[23 - n / 2] : 1'b0;
      eValid = !eCs && n >= 48 && ((n - 48) % 16 == 15);
    end
    if (eValid) expData = memByte(base + (n - 48) / 16);
    chk((mBusy != 0 && !eCs) ? "R2 csN" : "R7 csN", {7'd0, csN}, {7'd0, eCs});
    chk("R3 sck", {7'd0, sckOut}, {7'd0, eSck});
    chk((mBusy != 0 && n < 48) ? "R3 mosi" : "R4 mosi", {7'd0, mosiOut}, {7'd0, eMosi});
    chk((mBusy != 0) ? "R8 busy" : "R7 busy", {7'd0, busy}, {7'd0, mBusy != 0});
    chk("R6 valid", {7'd0, byteValid}, {7'd0, eValid});
    chk("R5 data", byteData, expData);
    startPulse = st;
    lastByte   = ls;
    addrHi     = hi;
    misoIn     = 1'b0;
    if (mBusy != 0 && !eCs && n >= 48) begin
      cur    = memByte(base + (n - 48) / 16);
      misoIn = cur[7 - ((n - 48) % 16) / 2];
    end
    @(posedge clk);
    if (mBusy == 0) begin
      if (st) begin
        mBusy = 1; n = 0; endAt = -1; base = {16'd0, hi, 12'h000};
      end
    end else begin
      if (eValid && ls) endAt = n + 3;
      n++;
      if (n == endAt) mBusy = 0;
    end
  endtask

  // Runs a burst of k bytes; optional injected start pulses that must be dropped (R8)
  task automatic runTxn(input logic [3:0] hi, input int k,
                        input bit injEarly, input bit injTail);
    logic st, ls;
    int   idx;
    step(1'b1, 1'b1, hi);
    #1 chk("R9 busy after start", {7'd0, busy}, 8'd1);
    while (mBusy != 0 && !done) begin
      idx = (n >= 48) ? (n - 48) / 16 : 0;
      if (n >= 48 && ((n - 48) % 16 == 15) && !(endAt >= 0))
        ls = (idx >= k - 1);           // R6 decision cycle
      else
        ls = ((n % 3) == 0);           // R6 noise outside valid cycles
      st = (injEarly && n == 20) || (injTail && endAt >= 0 && n == endAt - 1);
      step(st, ls, ~hi);               // addrHi changes after capture (R2)
    end
  endtask

  initial begin
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 csN", {7'd0, csN}, 8'd1);
    chk("R1 sck", {7'd0, sckOut}, 8'd0);
    chk("R1 mosi", {7'd0, mosiOut}, 8'd0);
    chk("R1 busy", {7'd0, busy}, 8'd0);
    chk("R1 valid", {7'd0, byteValid}, 8'd0);
    chk("R1 data", byteData, 8'd0);
    rstN = 1'b1;
    repeat (2) step(1'b0, 1'b0, 4'h0);
    runTxn(4'hA, 1, 1'b0, 1'b0);   // single byte
    runTxn(4'h5, 3, 1'b1, 1'b1);   // streaming, dropped starts (R8), back-to-back (R9)
    runTxn(4'h0, 2, 1'b0, 1'b0);   // R9 start in first idle cycle
    repeat (3) step(1'b0, 1'b1, 4'h7);
    runTxn(4'hF, 4, 1'b0, 1'b1);
    runTxn(4'h3, 1, 1'b1, 1'b0);
    repeat (4) step(1'b0, 1'b0, 4'h0);
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errs++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule